// File: doc/BRIEF.md
# UART Register-Bus Setup and Polled Responder

This block is the host side of a discrete 16550-compatible UART. It drives the UART's parallel register port: a 3-bit register address, an 8-bit write bus, an 8-bit read bus, a chip select, and separate read and write strobes. After reset it programs the UART for 115200 baud from a clock of about 14.7 MHz. It selects the divide-by-four prescaler, opens the divisor latch, loads both divisor bytes, and then closes the latch with an 8-N-1 line format.

After that the block runs a polled loop with the FIFOs off. It reads the line status register until the data-ready bit is set, then fetches the received byte. It reads line status again until the transmit-holding-empty bit is set, then writes back a response byte. The response is the received byte with the case of ASCII letters swapped. No interrupt line is used.

Every register access uses a fixed bus cycle. There is one setup cycle. The strobe and chip select are then held for a parameterized number of clocks, followed by one hold cycle.

Top module: `uart_host_ctrl`

## Requirements
- R1: While rst_ni is low, cs_o, rd_o and wr_o are all 0.
- R2: Each access holds cs_o together with exactly one strobe (rd_o or wr_o) for exactly STROBE_CYC consecutive clocks. addr_o and wdata_o hold the same value in the cycle before the strobe rises and in the cycle after it falls. rd_o and wr_o are never high together.
- R3: The first write after reset goes to offset 4 (modem control) with data 0x80, setting the prescaler-select bit 7.
- R4: The second write goes to offset 3 (line control) with data 0x80, setting the divisor-access bit 7.
- R5: The third write goes to offset 1 with DIVISOR[15:8]. The fourth write goes to offset 0 with DIVISOR[7:0].
- R6: The fifth write goes to offset 3 with data 0x03, which clears bit 7. No later write targets any offset other than 0.
- R7: After configuration, offset 5 (line status) is read repeatedly. Offset 0 is read only when the most recent line status read returned bit 0 = 1.
- R8: A write to offset 0 after configuration happens only when the most recent line status read returned bit 5 = 1. Each such indication allows at most one write.
- R9: The byte written back is the received byte with 0x20 toggled when it lies in 0x41..0x5A or 0x61..0x7A. Any other byte is returned unchanged.
- R10: Every received byte gets exactly one response write, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_o | output | 3 | UART register offset |
| wdata_o | output | 8 | Data written to the UART |
| rdata_i | input | 8 | Data read from the UART |
| cs_o | output | 1 | Chip select, active high |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |

## Verification
A register model in the bench answers line status reads from two flags and returns a received byte at offset 0. All 256 byte values are swept through it, which separates the case-swapped letter ranges from their edge neighbours (0x40, 0x5B, 0x60, 0x7B) and from bytes that must pass unchanged. On every fourth byte the transmit-empty flag is held low for a long stretch, which tells correct status gating apart from writing as soon as the byte is read. An idle stretch with data-ready low shows that polling alone never reads or writes the data register. After the sweep, a final wait with transmit-empty high and no data pending shows that one indication never yields a second write.

// File: rtl/uhc_pkg.sv
package uhc_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] OFS_DATA = 3'd0;
  localparam logic [AW-1:0] OFS_DLM  = 3'd1;
  localparam logic [AW-1:0] OFS_LCR  = 3'd3;
  localparam logic [AW-1:0] OFS_MCR  = 3'd4;
  localparam logic [AW-1:0] OFS_LSR  = 3'd5;

  localparam int unsigned LSR_DR_BIT   = 0;
  localparam int unsigned LSR_THRE_BIT = 5;

  localparam logic [DW-1:0] MCR_PRESCALE = 8'h80;
  localparam logic [DW-1:0] LCR_LATCH    = 8'h80;
  localparam logic [DW-1:0] LCR_8N1      = 8'h03;

  localparam int unsigned CFG_LEN = 5;
  localparam int unsigned IW      = $clog2(CFG_LEN);

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } cfg_wr_t;

  typedef enum logic [2:0] {
    ST_CFG,
    ST_POLL_RX,
    ST_GET_RX,
    ST_POLL_TX,
    ST_PUT_TX
  } ctrl_st_e;

  typedef enum logic [1:0] {
    BC_IDLE,
    BC_SETUP,
    BC_STRB,
    BC_HOLD
  } bus_st_e;
endpackage

// File: rtl/uhc_cfg_rom.sv
module uhc_cfg_rom
  import uhc_pkg::*;
#(
  parameter logic [15:0] DIVISOR = 16'h0002
) (
  input  logic [IW-1:0] idx_i,
  output cfg_wr_t       entry_o
);
  always_comb begin
    unique case (idx_i)
      IW'(0):  entry_o = '{addr: OFS_MCR,  data: MCR_PRESCALE};
      IW'(1):  entry_o = '{addr: OFS_LCR,  data: LCR_LATCH};
      IW'(2):  entry_o = '{addr: OFS_DLM,  data: DIVISOR[15:8]};
      IW'(3):  entry_o = '{addr: OFS_DATA, data: DIVISOR[7:0]};
      default: entry_o = '{addr: OFS_LCR,  data: LCR_8N1};
    endcase
  end
endmodule

// File: rtl/uhc_resp_map.sv
module uhc_resp_map
  import uhc_pkg::*;
(
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] byte_o
);
  logic is_upper, is_lower;

  assign is_upper = (byte_i >= 8'h41) && (byte_i <= 8'h5A);
  assign is_lower = (byte_i >= 8'h61) && (byte_i <= 8'h7A);
  assign byte_o   = (is_upper || is_lower) ? (byte_i ^ 8'h20) : byte_i;
endmodule

// File: rtl/uhc_bus_cycle.sv
module uhc_bus_cycle
  import uhc_pkg::*;
#(
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          cs_o,
  output logic          rd_o,
  output logic          wr_o
);
  localparam int unsigned CW = $clog2(STROBE_CYC + 1);

  bus_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BC_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        BC_IDLE: if (start_i) begin
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          st_q    <= BC_SETUP;
        end
        BC_SETUP: begin
          cnt_q <= '0;
          st_q  <= BC_STRB;
        end
        BC_STRB: begin
          if (cnt_q == CW'(STROBE_CYC - 1)) begin
            if (!we_q) rdata_q <= rdata_i;
            st_q <= BC_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= BC_IDLE;
      endcase
    end
  end

  assign idle_o  = (st_q == BC_IDLE);
  assign done_o  = (st_q == BC_HOLD);
  assign rdata_o = rdata_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign cs_o    = (st_q == BC_STRB);
  assign rd_o    = cs_o && !we_q;
  assign wr_o    = cs_o && we_q;
endmodule

// File: rtl/uart_host_ctrl.sv
module uart_host_ctrl
  import uhc_pkg::*;
#(
  parameter int unsigned STROBE_CYC = 2,
  parameter logic [15:0] DIVISOR    = 16'h0002
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] addr_o,
  output logic [7:0] wdata_o,
  input  logic [7:0] rdata_i,
  output logic       cs_o,
  output logic       rd_o,
  output logic       wr_o
);
  ctrl_st_e      st_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] rx_q;
  cfg_wr_t       cfg_entry;
  logic [DW-1:0] resp_byte;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_idle, bus_done;
  logic [DW-1:0] bus_rdata;

  uhc_cfg_rom #(.DIVISOR(DIVISOR)) u_cfg (
    .idx_i   (idx_q),
    .entry_o (cfg_entry)
  );

  uhc_resp_map u_map (
    .byte_i (rx_q),
    .byte_o (resp_byte)
  );

  always_comb begin
    bus_we    = 1'b0;
    bus_addr  = OFS_LSR;
    bus_wdata = '0;
    unique case (st_q)
      ST_CFG: begin
        bus_we    = 1'b1;
        bus_addr  = cfg_entry.addr;
        bus_wdata = cfg_entry.data;
      end
      ST_GET_RX: bus_addr = OFS_DATA;
      ST_PUT_TX: begin
        bus_we    = 1'b1;
        bus_addr  = OFS_DATA;
        bus_wdata = resp_byte;
      end
      default: ;
    endcase
  end

  uhc_bus_cycle #(.STROBE_CYC(STROBE_CYC)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bus_idle),
    .we_i    (bus_we),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .idle_o  (bus_idle),
    .done_o  (bus_done),
    .rdata_o (bus_rdata),
    .rdata_i (rdata_i),
    .addr_o  (addr_o),
    .wdata_o (wdata_o),
    .cs_o    (cs_o),
    .rd_o    (rd_o),
    .wr_o    (wr_o)
  );

  // state advances in the hold cycle, so the next access starts right after
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_CFG;
      idx_q <= '0;
      rx_q  <= '0;
    end else if (bus_done) begin
      unique case (st_q)
        ST_CFG: begin
          if (idx_q == IW'(CFG_LEN - 1)) st_q <= ST_POLL_RX;
          else idx_q <= idx_q + 1'b1;
        end
        ST_POLL_RX: if (bus_rdata[LSR_DR_BIT]) st_q <= ST_GET_RX;
        ST_GET_RX: begin
          rx_q <= bus_rdata;
          st_q <= ST_POLL_TX;
        end
        ST_POLL_TX: if (bus_rdata[LSR_THRE_BIT]) st_q <= ST_PUT_TX;
        default: st_q <= ST_POLL_RX;
      endcase
    end
  end
endmodule

// File: rtl/uhc_chk.sv
module uhc_chk #(
  parameter int unsigned STROBE_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] addr_o,
  input logic [7:0] wdata_o,
  input logic       lsr_dr_i,
  input logic       lsr_thre_i,
  input logic       cs_o,
  input logic       rd_o,
  input logic       wr_o
);
  localparam int unsigned RW = $clog2(STROBE_CYC + 2);

  logic [RW-1:0] run_q;
  logic [2:0]    cfg_cnt_q;
  logic          cs_d, wr_d, rd_d;
  logic          dr_ok_q, thre_ok_q;
  logic          acc_end;

  assign acc_end = cs_d && !cs_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      cfg_cnt_q <= '0;
      cs_d      <= 1'b0;
      wr_d      <= 1'b0;
      rd_d      <= 1'b0;
      dr_ok_q   <= 1'b0;
      thre_ok_q <= 1'b0;
    end else begin
      cs_d  <= cs_o;
      wr_d  <= wr_o;
      rd_d  <= rd_o;
      run_q <= cs_o ? run_q + 1'b1 : '0;
      if (acc_end && wr_d && cfg_cnt_q != 3'd5) cfg_cnt_q <= cfg_cnt_q + 1'b1;
      if (cs_o && rd_o && addr_o == 3'd5) begin
        dr_ok_q   <= lsr_dr_i;
        thre_ok_q <= lsr_thre_i;
      end else if (acc_end && rd_d && addr_o == 3'd0) begin
        dr_ok_q <= 1'b0;
      end else if (acc_end && wr_d && addr_o == 3'd0 && cfg_cnt_q == 3'd5) begin
        thre_ok_q <= 1'b0;
      end
    end
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  // R2
  cs_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o == (rd_o || wr_o));
  // R2
  setup_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> $stable(addr_o) && $stable(wdata_o));
  // R2
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> $stable(addr_o) && $stable(wdata_o));
  // R2
  strobe_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> run_q == RW'(STROBE_CYC));
  // R2
  strobe_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> run_q < RW'(STROBE_CYC));
  // R7
  rx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_o) && rd_o && addr_o == 3'd0) |-> dr_ok_q);
  // R8
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_o) && wr_o && addr_o == 3'd0 && cfg_cnt_q == 3'd5) |-> thre_ok_q);
  // R6
  cfg_only_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_o) && wr_o && cfg_cnt_q == 3'd5) |-> addr_o == 3'd0);
endmodule

bind uart_host_ctrl uhc_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_o     (addr_o),
  .wdata_o    (wdata_o),
  .lsr_dr_i   (rdata_i[0]),
  .lsr_thre_i (rdata_i[5]),
  .cs_o       (cs_o),
  .rd_o       (rd_o),
  .wr_o       (wr_o)
);

// File: tb/tb_uart_host_ctrl.sv
module tb_uart_host_ctrl;
  localparam int unsigned TB_STROBE = 3;
  localparam logic [15:0] TB_DIV    = 16'h0A02;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       cs, rd, wr;

  logic       m_dr, m_thre;
  logic [7:0] m_rx;

  int total = 0, bad = 0;
  int wr_cnt = 0, thr_cnt = 0, rhr_reads = 0, lsr_reads = 0, stray_cnt = 0;
  int len_bad = 0, run = 0;
  logic [7:0] last_tx = 8'h00;
  logic [2:0] w_addr [8];
  logic [7:0] w_data [8];
  logic       cs_p = 1'b0, wr_p = 1'b0, rd_p = 1'b0;
  logic [2:0] addr_p = 3'd0;
  logic [7:0] wdata_p = 8'h00;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  uart_host_ctrl #(.STROBE_CYC(TB_STROBE), .DIVISOR(TB_DIV)) dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_o  (addr),
    .wdata_o (wdata),
    .rdata_i (rdata),
    .cs_o    (cs),
    .rd_o    (rd),
    .wr_o    (wr)
  );

  always_comb begin
    case (addr)
      3'd5:    rdata = {2'b00, m_thre, 4'b0000, m_dr};
      3'd0:    rdata = m_rx;
      default: rdata = 8'h00;
    endcase
  end

  // bus monitor: logs each access when its strobe ends
  always @(negedge clk) begin
    if (cs) run = run + 1;
    if (rd && wr) len_bad = len_bad + 1;
    if (cs_p && !cs) begin
      if (run != TB_STROBE) len_bad = len_bad + 1;
      run = 0;
      if (wr_p) begin
        if (wr_cnt < 8) begin
          w_addr[wr_cnt] = addr_p;
          w_data[wr_cnt] = wdata_p;
        end
        if (wr_cnt >= 5) begin
          if (addr_p != 3'd0) stray_cnt = stray_cnt + 1;
          else begin
            thr_cnt = thr_cnt + 1;
            last_tx = wdata_p;
          end
        end
        wr_cnt = wr_cnt + 1;
      end
      if (rd_p) begin
        if (addr_p == 3'd5) lsr_reads = lsr_reads + 1;
        if (addr_p == 3'd0 && wr_cnt >= 5) rhr_reads = rhr_reads + 1;
      end
    end
    cs_p = cs; wr_p = wr; rd_p = rd; addr_p = addr; wdata_p = wdata;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_resp(input int b);
    if (b >= 8'h41 && b <= 8'h5A) return b + 32;
    if (b >= 8'h61 && b <= 8'h7A) return b - 32;
    return b;
  endfunction

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; m_dr = 1'b0; m_thre = 1'b1; m_rx = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset strobes", int'({cs, rd, wr}), 0);
    rst_n = 1'b1;

    while (wr_cnt < 5) @(negedge clk);
    check("R3 mcr addr", int'(w_addr[0]), 4);
    check("R3 mcr data", int'(w_data[0]), 8'h80);
    check("R4 lcr addr", int'(w_addr[1]), 3);
    check("R4 lcr data", int'(w_data[1]), 8'h80);
    check("R5 dlm addr", int'(w_addr[2]), 1);
    check("R5 dlm data", int'(w_data[2]), int'(TB_DIV[15:8]));
    check("R5 dll addr", int'(w_addr[3]), 0);
    check("R5 dll data", int'(w_data[3]), int'(TB_DIV[7:0]));
    check("R6 lcr addr", int'(w_addr[4]), 3);
    check("R6 lcr data", int'(w_data[4]), 8'h03);

    repeat (200) @(negedge clk);
    check("R7 no rhr read while idle", rhr_reads, 0);
    check("R8 no thr write while idle", thr_cnt, 0);
    check("R7 lsr polled", int'(lsr_reads > 10), 1);

    for (int b = 0; b < 256; b++) begin
      int n_rx, n_tx;
      n_rx = rhr_reads;
      n_tx = thr_cnt;
      m_rx   = 8'(b);
      m_thre = (b % 4 != 0);
      m_dr   = 1'b1;
      while (rhr_reads == n_rx) @(negedge clk);
      m_dr = 1'b0;
      if (!m_thre) begin
        repeat (40) @(negedge clk);
        check("R8 write held while not empty", thr_cnt, n_tx);
        m_thre = 1'b1;
      end
      while (thr_cnt == n_tx) @(negedge clk);
      m_thre = 1'b0;
      check("R9 response byte", int'(last_tx), exp_resp(b));
    end

    m_thre = 1'b1;
    repeat (60) @(negedge clk);
    check("R8 one write per indication", thr_cnt, 256);
    check("R10 rx count", rhr_reads, 256);
    check("R6 no stray writes", stray_cnt, 0);
    check("R2 strobe shape", len_bad, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule